// File: doc/BRIEF.md
# Clocked Serial Master with 16-Entry Shared Buffer

This block is a synchronous serial master that transmits and receives through one 16-slot byte buffer. The host queues bytes by pulsing a write strobe; the block shifts each queued byte out MSB first on `mosi` against a generated serial clock and samples `miso` on the same clock. When receive is enabled, the received byte is written back into the slot whose byte was just sent, so after a run the host reads the answers from the slots where the requests were.

The serial clock idles low. Data changes after a falling edge and is sampled by the block at the end of each high phase. Each phase lasts `div_sel + 1` system clocks. The divisor, the transmit enable and the receive enable are captured when a word starts. Buffer pointers stay where they are until the host clears them, the power control drops, or the buffer drains. Bytes already queued therefore start shifting as soon as an enable rises.

Engine states: IDLE (serial clock low, waiting for work), LOW (low phase, `mosi` holds the current bit), HIGH (high phase; `miso` is sampled as the phase ends), DONE (one cycle to write back the byte and advance the pointer). Transitions: IDLE→LOW on start, LOW→HIGH when the phase count expires, HIGH→LOW for the next bit, HIGH→DONE after the eighth bit, DONE→IDLE always. Any state goes to IDLE on abort (power low or pointer clear).

Top module: `qser_core`

## Requirements
- R1: While `ctl_pwr` is 0, every pointer is held at zero. Status reads full=0, empty=1, ptr=0, `sclk` stays low, no interrupt pulses, and writes are ignored. Raising `ctl_pwr` does not by itself start any transfer.
- R2: With `ctl_pwr`=1, a write (`wr_en`=1 for one cycle) while not full stores `wr_data` in the next free slot, numbered from 0. Empty drops, and after 16 accepted writes full reads 1. `rd_data` shows the slot selected by `rd_idx`, with no added delay.
- R3: A write while full is dropped and never shifted out. `irq_ovf` is high for exactly one cycle, in the cycle after the write.
- R4: `ptr_clr`=1 (with power on) zeroes all pointers, so status reads full=0, empty=1, ptr=0. It returns the engine to IDLE and drops a write in the same cycle. Queued bytes are discarded and are not sent when an enable is later set.
- R5: Bytes queued while both enables are 0 are held without serial activity. When either enable goes to 1 they shift out in slot order.
- R6: Each word is 8 bits, MSB first. `sclk` idles low, `mosi` is stable at every rising `sclk` edge, and each high phase lasts `div_sel`+1 clocks.
- R7: `miso` is sampled once per bit, MSB first. If `rx_en` was 1 at word start, the received byte replaces the slot just sent; otherwise that slot keeps its value. With `tx_en`=0 and `rx_en`=1, `mosi` carries zeros.
- R8: `st_ptr` is the slot of the next byte to shift. It rises by one per completed word and otherwise changes only by returning to 0.
- R9: When the last queued word completes, the pointers return to 0 (full=0, empty=1, ptr=0), and `irq_done` pulses for one cycle. The status is then identical to the status after a pointer clear.
- R10: Dropping both enables in the middle of a word lets that word finish. The engine then idles with the remaining bytes still queued, and they resume when an enable returns.
- R11: A write that coincides with the completion of the last queued word is accepted when not full: pointers keep advancing, there is no `irq_done`, and the new byte is sent next. When full, the write overflows (R3) and the drain to zero still happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_pwr | input | 1 | Power control; 0 holds the unit in reset |
| tx_en | input | 1 | Transmit enable (buffer bytes go out on `mosi`) |
| rx_en | input | 1 | Receive enable (received bytes written back) |
| ptr_clr | input | 1 | Pointer clear command, one-cycle pulse |
| div_sel | input | 4 | Phase length minus one, in system clocks |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write byte |
| rd_idx | input | 4 | Host read slot select |
| rd_data | output | 8 | Content of the selected slot |
| st_full | output | 1 | Buffer full status |
| st_empty | output | 1 | No byte waiting to be shifted |
| st_ptr | output | 4 | Slot of the next byte to shift |
| irq_ovf | output | 1 | Overflow interrupt pulse |
| irq_done | output | 1 | Buffer drained interrupt pulse |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Two things can land in the same clock: the completion of the final queued word, which drains the pointers and fires `irq_done`, and a host write, which either advances the write pointer or overflows. The bench finds the completion cycle by counting falling `sclk` edges and presents the write exactly in the DONE cycle. It does this once with a single byte queued and once with the buffer full. It then judges by the bytes seen on `mosi`, the number of `irq_done` and `irq_ovf` pulses, and the final status.

// File: rtl/qser_pkg.sv
package qser_pkg;
    localparam int unsigned QS_DATA_W = 8;
    localparam int unsigned QS_DEPTH  = 16;
    localparam int unsigned QS_DIV_W  = 4;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_LOW  = 2'd1,
        ENG_HIGH = 2'd2,
        ENG_DONE = 2'd3
    } eng_state_e;
endpackage

// File: rtl/qser_buf.sv
module qser_buf #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_slot,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wb_en,
    input  logic [AW-1:0]     wb_slot,
    input  logic [DATA_W-1:0] wb_data,
    input  logic [AW-1:0]     sh_slot,
    output logic [DATA_W-1:0] sh_data,
    input  logic [AW-1:0]     rd_slot,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slot_q [DEPTH];

    // Host write and receive write-back never target the same slot:
    // write-back uses the send slot, which is always below the write slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (wr_en && wr_slot == AW'(g)) begin
                q <= wr_data;
            end else if (wb_en && wb_slot == AW'(g)) begin
                q <= wb_data;
            end
        end
        assign slot_q[g] = q;
    end

    assign sh_data = slot_q[sh_slot];
    assign rd_data = slot_q[rd_slot];
endmodule

// File: rtl/qser_ptr.sv
module qser_ptr #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr,
    input  logic          clr,
    input  logic          wr_req,
    input  logic          word_done,
    output logic          wr_acc,
    output logic [AW-1:0] wr_slot,
    output logic [AW-1:0] sh_slot,
    output logic          full,
    output logic          empty,
    output logic          irq_ovf,
    output logic          irq_done
);
    logic [PW-1:0] wp, sp, sp_inc;
    logic          live, ovf_now, drain;

    always_comb begin
        live    = pwr && !clr;
        full    = (wp == PW'(DEPTH));
        empty   = (wp == sp);
        wr_acc  = live && wr_req && !full;
        ovf_now = live && wr_req && full;
        sp_inc  = sp + 1'b1;
        // last queued word completes with no write landing beside it
        drain   = live && word_done && !wr_acc && (sp_inc == wp);
        wr_slot = wp[AW-1:0];
        sh_slot = sp[AW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp <= '0;
            sp <= '0;
        end else if (!live || drain) begin
            wp <= '0;
            sp <= '0;
        end else begin
            if (wr_acc)    wp <= wp + 1'b1;
            if (word_done) sp <= sp_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_ovf  <= 1'b0;
            irq_done <= 1'b0;
        end else begin
            irq_ovf  <= ovf_now;
            irq_done <= drain;
        end
    end
endmodule

// File: rtl/qser_shift.sv
module qser_shift
    import qser_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 4,
    localparam int BW    = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              have_data,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              word_done,
    output logic              wb_en,
    output logic [DATA_W-1:0] wb_data
);
    eng_state_e        st, st_n;
    logic [DIV_W-1:0]  cnt, div_q;
    logic [BW-1:0]     bitn;
    logic [DATA_W-1:0] txsh, rxsh;
    logic              rx_mode;
    logic              cnt_zero, last_bit, start;

    // next-state logic
    always_comb begin
        cnt_zero = (cnt == '0);
        last_bit = (bitn == BW'(DATA_W - 1));
        start    = have_data && (tx_en || rx_en);
        st_n     = st;
        if (abort) begin
            st_n = ENG_IDLE;
        end else begin
            unique case (st)
                ENG_IDLE: if (start)    st_n = ENG_LOW;
                ENG_LOW:  if (cnt_zero) st_n = ENG_HIGH;
                ENG_HIGH: if (cnt_zero) st_n = last_bit ? ENG_DONE : ENG_LOW;
                ENG_DONE: st_n = ENG_IDLE;
                default:  st_n = ENG_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ENG_IDLE;
        else        st <= st_n;
    end

    // datapath: shift registers, phase counter, word settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            div_q   <= '0;
            bitn    <= '0;
            txsh    <= '0;
            rxsh    <= '0;
            rx_mode <= 1'b0;
        end else begin
            unique case (st)
                ENG_IDLE: begin
                    if (st_n == ENG_LOW) begin
                        txsh    <= tx_en ? tx_byte : '0;
                        rx_mode <= rx_en;
                        div_q   <= div_sel;
                        cnt     <= div_sel;
                        bitn    <= '0;
                    end
                end
                ENG_LOW: begin
                    cnt <= cnt_zero ? div_q : cnt - 1'b1;
                end
                ENG_HIGH: begin
                    if (cnt_zero) begin
                        rxsh <= {rxsh[DATA_W-2:0], miso};
                        cnt  <= div_q;
                        if (!last_bit) begin
                            txsh <= {txsh[DATA_W-2:0], 1'b0};
                            bitn <= bitn + 1'b1;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ENG_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sclk      = (st == ENG_HIGH);
        mosi      = ((st == ENG_LOW) || (st == ENG_HIGH)) && txsh[DATA_W-1];
        word_done = (st == ENG_DONE);
        wb_en     = word_done && rx_mode && !abort;
        wb_data   = rxsh;
    end
endmodule

// File: rtl/qser_core.sv
module qser_core
    import qser_pkg::*;
#(
    parameter int DATA_W = QS_DATA_W,
    parameter int DEPTH  = QS_DEPTH,
    parameter int DIV_W  = QS_DIV_W,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_pwr,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              ptr_clr,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              st_full,
    output logic              st_empty,
    output logic [AW-1:0]     st_ptr,
    output logic              irq_ovf,
    output logic              irq_done,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);
    logic              wr_acc, word_done, wb_en, abort;
    logic [AW-1:0]     wr_slot, sh_slot;
    logic [DATA_W-1:0] sh_data, wb_data;

    assign abort  = !ctl_pwr || ptr_clr;
    assign st_ptr = sh_slot;

    qser_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr      (ctl_pwr),
        .clr      (ptr_clr),
        .wr_req   (wr_en),
        .word_done(word_done),
        .wr_acc   (wr_acc),
        .wr_slot  (wr_slot),
        .sh_slot  (sh_slot),
        .full     (st_full),
        .empty    (st_empty),
        .irq_ovf  (irq_ovf),
        .irq_done (irq_done)
    );

    qser_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
        .clk    (clk),
        .wr_en  (wr_acc),
        .wr_slot(wr_slot),
        .wr_data(wr_data),
        .wb_en  (wb_en),
        .wb_slot(sh_slot),
        .wb_data(wb_data),
        .sh_slot(sh_slot),
        .sh_data(sh_data),
        .rd_slot(rd_idx),
        .rd_data(rd_data)
    );

    qser_shift #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .abort    (abort),
        .tx_en    (tx_en),
        .rx_en    (rx_en),
        .have_data(!st_empty),
        .div_sel  (div_sel),
        .tx_byte  (sh_data),
        .miso     (miso),
        .sclk     (sclk),
        .mosi     (mosi),
        .word_done(word_done),
        .wb_en    (wb_en),
        .wb_data  (wb_data)
    );
endmodule

// File: rtl/qser_chk.sv
module qser_chk #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctl_pwr,
    input logic          ptr_clr,
    input logic          wr_en,
    input logic          st_full,
    input logic          st_empty,
    input logic [AW-1:0] st_ptr,
    input logic          irq_ovf,
    input logic          irq_done,
    input logic          sclk,
    input logic          mosi
);
    a_r1_power_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_pwr |=> (st_empty && !st_full && st_ptr == '0 && !sclk && !irq_ovf && !irq_done));

    a_r2_full_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_full && st_empty));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_pwr && !ptr_clr && wr_en && st_full) |=> irq_ovf);

    a_r3_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ovf |-> $past(wr_en && st_full));

    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_pwr && ptr_clr) |=> (st_empty && !st_full && st_ptr == '0 && !sclk));

    a_r6_mosi_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi));

    a_r8_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_ptr != $past(st_ptr)) |-> (st_ptr == AW'($past(st_ptr) + 1'b1) || st_ptr == '0));

    a_r9_drain_status: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> (st_empty && !st_full && st_ptr == '0));
endmodule

bind qser_core qser_chk #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_pwr (ctl_pwr),
    .ptr_clr (ptr_clr),
    .wr_en   (wr_en),
    .st_full (st_full),
    .st_empty(st_empty),
    .st_ptr  (st_ptr),
    .irq_ovf (irq_ovf),
    .irq_done(irq_done),
    .sclk    (sclk),
    .mosi    (mosi)
);

// File: tb/sim_qser_core.sv
module sim_qser_core;
    logic       clk = 0, rst_n = 0, ctl_pwr = 0, tx_en = 0, rx_en = 0, ptr_clr = 0;
    logic       wr_en = 0, miso = 0;
    logic [3:0] div_sel = 0, rd_idx = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic       st_full, st_empty, irq_ovf, irq_done, sclk, mosi;
    logic [3:0] st_ptr;

    qser_core u0 (
        .clk(clk), .rst_n(rst_n), .ctl_pwr(ctl_pwr), .tx_en(tx_en), .rx_en(rx_en),
        .ptr_clr(ptr_clr), .div_sel(div_sel), .wr_en(wr_en), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .st_full(st_full), .st_empty(st_empty),
        .st_ptr(st_ptr), .irq_ovf(irq_ovf), .irq_done(irq_done), .sclk(sclk),
        .mosi(mosi), .miso(miso)
    );

    always #10 clk = ~clk;

    int total = 0, bad = 0;
    bit ended = 0;
    logic [7:0] capt [256];
    int capn = 0, cb = 0, sn = 0, ndone = 0, novf = 0, hicnt = 0;
    logic [7:0] cur = 0;
    logic prev_sclk = 0;
    logic [7:0] qd [16];

    function automatic logic [7:0] sbyte(int k);
        return 8'(8'h5A + k * 29);
    endfunction

    function automatic logic sbit(int n);
        logic [7:0] b;
        b = sbyte(n / 8);
        return b[7 - (n % 8)];
    endfunction

    // monitor and serial slave, all at the falling system clock
    initial forever begin
        @(negedge clk);
        if (irq_done) ndone++;
        if (irq_ovf)  novf++;
        if (sclk)     hicnt++;
        if (!prev_sclk && sclk) begin
            cur = {cur[6:0], mosi};
            cb++;
            if (cb == 8) begin
                if (capn < 256) capt[capn] = cur;
                capn++;
                cb = 0;
            end
        end
        if (prev_sclk && !sclk) begin
            sn++;
            miso = sbit(sn);
        end
        prev_sclk = sclk;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic fresh();
        step();
        capn = 0; cb = 0; sn = 0; miso = sbit(0);
        ndone = 0; novf = 0; hicnt = 0;
    endtask

    task automatic wr(input logic [7:0] b);
        wr_en = 1; wr_data = b;
        step();
        wr_en = 0;
    endtask

    task automatic pclr();
        ptr_clr = 1;
        step();
        ptr_clr = 0;
        step();
    endtask

    task automatic drain();
        for (int i = 0; i < 20000; i++) begin
            if (st_empty && !sclk) break;
            step();
        end
        repeat (4) step();
    endtask

    task automatic wait_falls(input int n);
        int k = 0;
        logic p = sclk;
        while (k < n) begin
            @(negedge clk);
            if (p && !sclk) k++;
            p = sclk;
        end
    endtask

    task automatic rd_chk(input int idx, input logic [7:0] exp, input string tag);
        rd_idx = 4'(idx);
        #1;
        chk(rd_data == exp, tag, rd_data, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) step();
        rst_n = 1;
        step();
        // R1: reset state
        chk(st_empty && !st_full && st_ptr == 0 && !sclk, "R1 reset status",
            {st_full, st_empty, st_ptr}, 6'b010000);
        wr(8'hAA);
        step();
        chk(st_empty == 1, "R1 write ignored with power off", st_empty, 1);

        // R2/R5: queue with enables off
        ctl_pwr = 1;
        fresh();
        wr(8'hA1); wr(8'hB2); wr(8'hC3);
        repeat (50) step();
        chk(!st_empty && !st_full && st_ptr == 0, "R2 status after three writes",
            {st_full, st_empty, st_ptr}, 6'b000000);
        chk(capn == 0 && hicnt == 0, "R5 no shifting while disabled", hicnt, 0);
        rd_chk(1, 8'hB2, "R2 readback slot1");

        // R5/R6/R7/R9: both enables, divisor 3
        div_sel = 3; tx_en = 1; rx_en = 1;
        drain();
        tx_en = 0; rx_en = 0;
        chk(capn == 3, "R5 word count", capn, 3);
        chk(capt[0] == 8'hA1 && capt[1] == 8'hB2 && capt[2] == 8'hC3, "R6 mosi bytes MSB first",
            capt[2], 8'hC3);
        chk(hicnt == 3 * 8 * 4, "R6 high phase length", hicnt, 96);
        chk(ndone == 1, "R9 one drain interrupt", ndone, 1);
        chk(st_empty && !st_full && st_ptr == 0, "R9 drained status",
            {st_full, st_empty, st_ptr}, 6'b010000);
        for (int i = 0; i < 3; i++) rd_chk(i, sbyte(i), "R7 received byte in slot");

        // R7: transmit only keeps slots
        fresh();
        wr(8'h11); wr(8'h22);
        div_sel = 0; tx_en = 1;
        drain();
        tx_en = 0;
        chk(capn == 2 && capt[1] == 8'h22, "R7 tx-only bytes", capt[1], 8'h22);
        rd_chk(0, 8'h11, "R7 tx-only slot0 unchanged");
        rd_chk(1, 8'h22, "R7 tx-only slot1 unchanged");

        // R7: receive only sends zeros
        fresh();
        wr(8'h33); wr(8'h44);
        rx_en = 1;
        drain();
        rx_en = 0;
        chk(capn == 2 && capt[0] == 0 && capt[1] == 0, "R7 rx-only mosi zeros", capt[0], 0);
        rd_chk(0, sbyte(0), "R7 rx-only slot0");
        rd_chk(1, sbyte(1), "R7 rx-only slot1");

        // R2/R3/R4: fill, overflow, clear
        fresh();
        for (int i = 0; i < 16; i++) wr(8'(i + 8'h80));
        chk(st_full && !st_empty && st_ptr == 0, "R2 full after 16", st_full, 1);
        wr(8'hEE);
        repeat (3) step();
        chk(novf == 1, "R3 one overflow pulse", novf, 1);
        chk(st_full == 1, "R3 still full", st_full, 1);
        pclr();
        chk(st_empty && !st_full && st_ptr == 0, "R4 status after clear",
            {st_full, st_empty, st_ptr}, 6'b010000);
        tx_en = 1;
        repeat (100) step();
        chk(capn == 0, "R4 cleared data not sent", capn, 0);
        tx_en = 0;

        // R3: dropped write never shifted
        fresh();
        for (int i = 0; i < 16; i++) wr(8'(i + 8'h40));
        wr(8'hEE);
        tx_en = 1;
        drain();
        tx_en = 0;
        chk(capn == 16 && capt[15] == 8'h4F, "R3 dropped write not sent", capt[15], 8'h4F);

        // R8/R10: enables dropped mid-word
        fresh();
        wr(8'h01); wr(8'h02); wr(8'h03); wr(8'h04);
        div_sel = 1; tx_en = 1;
        wait_falls(3);
        #1 tx_en = 0;
        repeat (60) step();
        chk(capn == 1 && capt[0] == 8'h01, "R10 word finishes", capn, 1);
        chk(st_ptr == 1 && !st_empty, "R8 pointer after one word", st_ptr, 1);
        tx_en = 1;
        drain();
        tx_en = 0;
        chk(capn == 4 && capt[3] == 8'h04, "R10 remaining words resume", capn, 4);

        // R11: write in the completion cycle, not full
        fresh();
        div_sel = 0;
        wr(8'h5C);
        tx_en = 1;
        wait_falls(8);
        wr_en = 1; wr_data = 8'h6D;
        step();
        wr_en = 0;
        drain();
        tx_en = 0;
        chk(capn == 2 && capt[1] == 8'h6D, "R11 coincident write sent", capt[1], 8'h6D);
        chk(ndone == 1, "R11 single drain interrupt", ndone, 1);

        // R11: write in the completion cycle, full
        fresh();
        for (int i = 0; i < 16; i++) wr(8'(i * 3));
        tx_en = 1;
        wait_falls(128);
        wr_en = 1; wr_data = 8'h77;
        step();
        wr_en = 0;
        repeat (4) step();
        tx_en = 0;
        chk(novf == 1 && ndone == 1, "R11 overflow and drain together", {novf[3:0], ndone[3:0]}, 8'h11);
        chk(st_empty && !st_full && st_ptr == 0, "R11 drained status",
            {st_full, st_empty, st_ptr}, 6'b010000);

        // R1: power off empties the queue
        fresh();
        wr(8'h99); wr(8'h98);
        ctl_pwr = 0;
        step();
        ctl_pwr = 1;
        step();
        chk(st_empty == 1, "R1 power off clears pointers", st_empty, 1);
        tx_en = 1;
        repeat (50) step();
        tx_en = 0;
        chk(capn == 0, "R1 no transfer after power cycle", capn, 0);

        // random runs
        for (int r = 0; r < 8; r++) begin
            int n, mode;
            fresh();
            pclr();
            n = 1 + ($urandom % 16);
            mode = 1 + ($urandom % 3);
            div_sel = 4'($urandom % 4);
            for (int i = 0; i < n; i++) begin
                qd[i] = 8'($urandom);
                wr(qd[i]);
            end
            tx_en = mode[0]; rx_en = mode[1];
            drain();
            tx_en = 0; rx_en = 0;
            chk(capn == n && ndone == 1, "R9 random run length", capn, n);
            for (int i = 0; i < n; i++) begin
                logic [7:0] em, es;
                em = mode[0] ? qd[i] : 8'h00;
                es = mode[1] ? sbyte(i) : qd[i];
                chk(capt[i] == em, "R6 random mosi byte", capt[i], em);
                rd_chk(i, es, "R7 random slot content");
            end
        end

        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule